// File: doc/BRIEF.md
# Instruction Exception Classifier

This block sits beside the issue stage of a processor pipeline. For each instruction about to execute, it looks at a small set of decoded facts and the processor state. From these it decides whether a synchronous exception must be taken and, if so, which vector number to use. The facts it checks are the control-transfer target, the first opword, bits 11:8 of the first extension word of an indexed effective address, the supervisor bit and a privileged-instruction flag.

When an instruction completes, the block also produces a trace exception if the status-register trace bit is set. The stop instruction is the only case that gets no trace. After a stop completes, the block waits for an unmasked interrupt to become pending and then pulses a pipeline-abort strobe, so that interrupt processing can begin.

All detection is limited to the listed encodings. Other unsupported opwords, and every extension-word bit outside the checked fields, pass through without an exception. Results are registered and appear one clock after the strobe that caused them.

Top module: `exc_classifier`

## Requirements
- R1: With issue_i and xfer_i high, a target address with bit 0 set gives exc_req_o=1 and exc_vec_o=3 one cycle later.
- R2: With issue_i and idx_mode_i high, ext_hi_i (extension word bits 11:8: bit 3 = index size with 0 meaning word, bits 2:1 = scale with 3 meaning x8, bit 0 = full format) gives vector 3 if the size bit is 0, the scale is 3 or the full-format bit is 1. When idx_mode_i is low, ext_hi_i is ignored.
- R3: On issue, opword 0x0000 or 0x4AFC gives vector 4.
- R4: On issue, an opword with top nibble 0xA gives vector 10, unless mac_en_i is 1 and opword bits 8:7 equal mac_pat_i. In that case there is no exception from this rule.
- R5: On issue, an opword with top nibble 0xF gives vector 11.
- R6: On issue, any other opword gives no exception when no other rule applies.
- R7: On issue, priv_instr_i=1 with super_i=0 gives vector 8. With super_i=1, this rule raises nothing.
- R8: done_i with trace_en_i=1 and stop_i=0 gives vector 9 one cycle later.
- R9: done_i with stop_i=1 never raises a trace. It arms a wait. The first cycle in which irq_pend_i is high while the wait is armed makes abort_o pulse high for exactly one cycle on the next clock and disarms the wait. irq_pend_i has no effect when the wait is not armed.
- R10: When several causes meet in one cycle, the vector follows this order: address error (3), then illegal/line A/line F (4, 10, 11), then privilege (8), then trace (9).
- R11: After reset, and in any cycle not following an issue_i or done_i strobe, exc_req_o=0 and exc_vec_o=0. abort_o is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction about to execute |
| xfer_i | input | 1 | Instruction transfers control |
| xfer_addr_i | input | AW | Control-transfer target address |
| opword_i | input | 16 | First opword |
| idx_mode_i | input | 1 | Indexed effective address in use |
| ext_hi_i | input | 4 | Bits 11:8 of the first extension word |
| mac_en_i | input | 1 | Multiply-accumulate unit present |
| mac_pat_i | input | 2 | Opword bits 8:7 pattern exempted on line A |
| super_i | input | 1 | Supervisor mode |
| priv_instr_i | input | 1 | Instruction is privileged |
| trace_en_i | input | 1 | Status-register trace bit |
| done_i | input | 1 | Instruction-complete strobe |
| stop_i | input | 1 | Completing instruction is stop |
| irq_pend_i | input | 1 | Unmasked interrupt pending |
| exc_req_o | output | 1 | Exception request |
| exc_vec_o | output | 8 | Exception vector number |
| abort_o | output | 1 | Pipeline abort pulse ending a stop wait |

## Verification
The bench sweeps every top nibble against low-bit patterns that include 0x000 and 0xAFC. This would expose a design that traps all of line 4 or misses the zero opword. It sweeps all sixteen extension-field values with the indexed flag both set and clear, which catches a design that checks extension bits when no indexed mode is in use. It sweeps every mac_en_i/mac_pat_i/opword bits 8:7 combination, which catches an exemption that is inverted or ignores the present flag. It also sweeps all 32 combinations of the five fault causes, so that any wrong ordering shows up as the wrong vector. A stop sequence checks that trace stays silent, that an interrupt with no armed wait does nothing, and that abort lasts a single cycle.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;
  typedef logic [7:0] vec_t;

  localparam vec_t VEC_NONE  = 8'd0;
  localparam vec_t VEC_ADDR  = 8'd3;
  localparam vec_t VEC_ILL   = 8'd4;
  localparam vec_t VEC_PRIV  = 8'd8;
  localparam vec_t VEC_TRACE = 8'd9;
  localparam vec_t VEC_LINEA = 8'd10;
  localparam vec_t VEC_LINEF = 8'd11;

  localparam logic [15:0] OP_ZERO    = 16'h0000;
  localparam logic [15:0] OP_ILLEGAL = 16'h4AFC;
  localparam logic [3:0]  NIB_LINEA  = 4'hA;
  localparam logic [3:0]  NIB_LINEF  = 4'hF;
  localparam logic [1:0]  SCALE_X8   = 2'b11;

  typedef struct packed {
    logic addr;
    logic ill;
    logic line_a;
    logic line_f;
    logic priv;
    logic trace;
  } cause_t;
endpackage

// File: rtl/exc_addr_chk.sv
module exc_addr_chk #(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] ALIGN_MASK = 1
) (
  input  logic          xfer_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          idx_i,
  input  logic [3:0]    ext_hi_i,
  output logic          addr_err_o
);
  import exc_cls_pkg::*;

  logic odd_tgt;
  logic idx_bad;
  logic size_word, scale_x8, full_fmt;

  assign size_word = ~ext_hi_i[3];
  assign scale_x8  = (ext_hi_i[2:1] == SCALE_X8);
  assign full_fmt  = ext_hi_i[0];

  assign odd_tgt    = xfer_i & (|(tgt_i & ALIGN_MASK));
  assign idx_bad    = idx_i & (size_word | scale_x8 | full_fmt);
  assign addr_err_o = odd_tgt | idx_bad;
endmodule

// File: rtl/exc_op_chk.sv
module exc_op_chk (
  input  logic [15:0] op_i,
  input  logic        mac_en_i,
  input  logic [1:0]  mac_pat_i,
  output logic        ill_o,
  output logic        line_a_o,
  output logic        line_f_o
);
  import exc_cls_pkg::*;

  logic mac_hit;

  assign mac_hit  = mac_en_i & (op_i[8:7] == mac_pat_i);
  assign ill_o    = (op_i == OP_ZERO) | (op_i == OP_ILLEGAL);
  assign line_a_o = (op_i[15:12] == NIB_LINEA) & ~mac_hit;
  assign line_f_o = (op_i[15:12] == NIB_LINEF);
endmodule

// File: rtl/exc_stop_ctl.sv
module exc_stop_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_done_i,
  input  logic irq_i,
  output logic abort_o
);
  logic wait_q;
  logic wake;

  assign wake = wait_q & irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= wake;
      if (wake)             wait_q <= 1'b0;
      else if (stop_done_i) wait_q <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier #(
  parameter int unsigned   AW         = 32,
  parameter logic [AW-1:0] ALIGN_MASK = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          xfer_i,
  input  logic [AW-1:0] xfer_addr_i,
  input  logic [15:0]   opword_i,
  input  logic          idx_mode_i,
  input  logic [3:0]    ext_hi_i,
  input  logic          mac_en_i,
  input  logic [1:0]    mac_pat_i,
  input  logic          super_i,
  input  logic          priv_instr_i,
  input  logic          trace_en_i,
  input  logic          done_i,
  input  logic          stop_i,
  input  logic          irq_pend_i,
  output logic          exc_req_o,
  output logic [7:0]    exc_vec_o,
  output logic          abort_o
);
  import exc_cls_pkg::*;

  logic   addr_err, ill, line_a, line_f;
  cause_t cause;
  vec_t   vec_d;
  logic   req_d;

  exc_addr_chk #(.AW(AW), .ALIGN_MASK(ALIGN_MASK)) u_addr (
    .xfer_i     (xfer_i),
    .tgt_i      (xfer_addr_i),
    .idx_i      (idx_mode_i),
    .ext_hi_i   (ext_hi_i),
    .addr_err_o (addr_err)
  );

  exc_op_chk u_op (
    .op_i      (opword_i),
    .mac_en_i  (mac_en_i),
    .mac_pat_i (mac_pat_i),
    .ill_o     (ill),
    .line_a_o  (line_a),
    .line_f_o  (line_f)
  );

  exc_stop_ctl u_stop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_done_i (done_i & stop_i),
    .irq_i       (irq_pend_i),
    .abort_o     (abort_o)
  );

  always_comb begin
    cause.addr   = issue_i & addr_err;
    cause.ill    = issue_i & ill;
    cause.line_a = issue_i & line_a;
    cause.line_f = issue_i & line_f;
    cause.priv   = issue_i & priv_instr_i & ~super_i;
    cause.trace  = done_i & trace_en_i & ~stop_i;
  end

  // fixed priority: address, opword class, privilege, trace
  always_comb begin
    req_d = 1'b1;
    if (cause.addr)        vec_d = VEC_ADDR;
    else if (cause.ill)    vec_d = VEC_ILL;
    else if (cause.line_a) vec_d = VEC_LINEA;
    else if (cause.line_f) vec_d = VEC_LINEF;
    else if (cause.priv)   vec_d = VEC_PRIV;
    else if (cause.trace)  vec_d = VEC_TRACE;
    else begin
      vec_d = VEC_NONE;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_req_o <= 1'b0;
      exc_vec_o <= VEC_NONE;
    end else begin
      exc_req_o <= req_d;
      exc_vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/exc_classifier_chk.sv
module exc_classifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       issue_i,
  input logic       xfer_i,
  input logic       odd_i,
  input logic       idx_mode_i,
  input logic [3:0] opnib_i,
  input logic       super_i,
  input logic       done_i,
  input logic       trace_en_i,
  input logic       stop_i,
  input logic       exc_req_o,
  input logic [7:0] exc_vec_o,
  input logic       abort_o
);
  p_odd_target_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && xfer_i && odd_i) |=> (exc_req_o && exc_vec_o == 8'd3));

  p_line_f_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && opnib_i == 4'hF && !xfer_i && !idx_mode_i) |=> (exc_req_o && exc_vec_o == 8'd11));

  p_super_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && super_i && !xfer_i && !idx_mode_i && opnib_i == 4'h3 && !done_i) |=> !exc_req_o);

  p_trace_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && trace_en_i && !stop_i && !issue_i) |=> (exc_req_o && exc_vec_o == 8'd9));

  p_stop_no_trace_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && stop_i && !issue_i) |=> !exc_req_o);

  p_abort_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i && !done_i) |=> !exc_req_o);

  p_vec_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_o |-> exc_vec_o == 8'd0);
endmodule

bind exc_classifier exc_classifier_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .xfer_i     (xfer_i),
  .odd_i      (xfer_addr_i[0]),
  .idx_mode_i (idx_mode_i),
  .opnib_i    (opword_i[15:12]),
  .super_i    (super_i),
  .done_i     (done_i),
  .trace_en_i (trace_en_i),
  .stop_i     (stop_i),
  .exc_req_o  (exc_req_o),
  .exc_vec_o  (exc_vec_o),
  .abort_o    (abort_o)
);

// File: tb/exc_classifier_bench.sv
module exc_classifier_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 0, xfer_i = 0, idx_mode_i = 0, mac_en_i = 0;
  logic [31:0] xfer_addr_i = '0;
  logic [15:0] opword_i = '0;
  logic [3:0]  ext_hi_i = 4'h8;
  logic [1:0]  mac_pat_i = '0;
  logic        super_i = 0, priv_instr_i = 0, trace_en_i = 0;
  logic        done_i = 0, stop_i = 0, irq_pend_i = 0;
  logic        exc_req_o, abort_o;
  logic [7:0]  exc_vec_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_classifier u_exc_classifier (.*);

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual req=%0b vec=%0d expected req=%0b vec=%0d",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // expected {req,vec} from the requirements
  function automatic logic [8:0] model(input logic iss, xf, a0, idx, input logic [3:0] ext,
                                       input logic [15:0] op, input logic me, input logic [1:0] mp,
                                       input logic sup, pr, dn, tr, st);
    if (iss && ((xf && a0) || (idx && (!ext[3] || ext[2:1] == 2'd3 || ext[0])))) return {1'b1, 8'd3};
    if (iss && (op == 16'h0000 || op == 16'h4AFC)) return {1'b1, 8'd4};
    if (iss && op[15:12] == 4'hA && !(me && op[8:7] == mp)) return {1'b1, 8'd10};
    if (iss && op[15:12] == 4'hF) return {1'b1, 8'd11};
    if (iss && pr && !sup) return {1'b1, 8'd8};
    if (dn && tr && !st) return {1'b1, 8'd9};
    return 9'd0;
  endfunction

  function automatic string tag(input logic [7:0] v);
    case (v)
      8'd3: return "R1/R2 address error";
      8'd4: return "R3 illegal opword";
      8'd10: return "R4 line A";
      8'd11: return "R5 line F";
      8'd8: return "R7 privilege";
      8'd9: return "R8 trace";
      default: return "R6 no exception";
    endcase
  endfunction

  task automatic idle();
    issue_i = 0; xfer_i = 0; xfer_addr_i = '0; idx_mode_i = 0; ext_hi_i = 4'h8;
    opword_i = 16'h3000; mac_en_i = 0; mac_pat_i = 0; super_i = 0; priv_instr_i = 0;
    trace_en_i = 0; done_i = 0; stop_i = 0; irq_pend_i = 0;
  endtask

  // inputs already set at a negedge; step one edge and compare
  task automatic step_and_check(input string pfx);
    logic [8:0] exp;
    exp = model(issue_i, xfer_i, xfer_addr_i[0], idx_mode_i, ext_hi_i, opword_i, mac_en_i,
                mac_pat_i, super_i, priv_instr_i, done_i, trace_en_i, stop_i);
    @(posedge clk_i);
    @(negedge clk_i);
    check({pfx, " ", tag(exp[7:0])}, {exc_req_o, exc_vec_o}, exp);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lows [6];
    lows = '{16'h000, 16'hAFC, 16'h180, 16'h080, 16'h123, 16'hFFF};
    idle();
    repeat (2) @(negedge clk_i);
    check("R11 reset state", {exc_req_o, exc_vec_o}, 9'd0);
    check("R11 reset abort", {8'd0, abort_o}, 9'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R5 R6: opword sweep
    for (int n = 0; n < 16; n++) begin
      for (int l = 0; l < 6; l++) begin
        issue_i = 1; super_i = 1; opword_i = {n[3:0], 12'h000} | lows[l];
        step_and_check("op sweep");
      end
    end

    // R1: target alignment
    for (int b = 0; b < 4; b++) begin
      issue_i = 1; super_i = 1; xfer_i = 1; xfer_addr_i = 32'h1000 | b;
      step_and_check("R1 target");
      issue_i = 1; super_i = 1; xfer_i = 0; xfer_addr_i = 32'h1000 | b;
      step_and_check("R1 no xfer");
    end

    // R2: extension field sweep, indexed flag on and off
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 2; m++) begin
        issue_i = 1; super_i = 1; idx_mode_i = m[0]; ext_hi_i = e[3:0];
        step_and_check("R2 ext");
      end
    end

    // R4: accumulate exemption sweep
    for (int me = 0; me < 2; me++)
      for (int mp = 0; mp < 4; mp++)
        for (int ob = 0; ob < 4; ob++) begin
          issue_i = 1; super_i = 1; mac_en_i = me[0]; mac_pat_i = mp[1:0];
          opword_i = 16'hA000 | (16'(ob) << 7);
          step_and_check("R4 mac");
        end

    // R7: privilege
    for (int s = 0; s < 4; s++) begin
      issue_i = 1; super_i = s[0]; priv_instr_i = s[1];
      step_and_check("R7 priv");
    end

    // R8: trace on completion
    for (int t = 0; t < 4; t++) begin
      done_i = t[0]; trace_en_i = t[1];
      step_and_check("R8 trace");
    end

    // R10: all five causes combined
    for (int c = 0; c < 32; c++) begin
      issue_i = 1; xfer_i = c[0]; xfer_addr_i = 32'h201;
      idx_mode_i = c[1]; ext_hi_i = 4'h1;
      opword_i = c[2] ? 16'h4AFC : 16'h3000;
      priv_instr_i = c[3]; super_i = 0;
      done_i = c[4]; trace_en_i = 1;
      step_and_check("R10 prio");
    end

    // R11: quiet cycle
    @(negedge clk_i);
    check("R11 quiet", {exc_req_o, exc_vec_o}, 9'd0);

    // R9: interrupt with no armed wait
    irq_pend_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 irq without wait", {8'd0, abort_o}, 9'd0);
    irq_pend_i = 0;

    // R9: stop completion suppresses trace, arms wait
    done_i = 1; stop_i = 1; trace_en_i = 1;
    @(negedge clk_i);
    check("R9 stop no trace", {exc_req_o, exc_vec_o}, 9'd0);
    check("R9 no early abort", {8'd0, abort_o}, 9'd0);
    idle();
    repeat (3) @(negedge clk_i);
    check("R9 waiting", {8'd0, abort_o}, 9'd0);
    irq_pend_i = 1;
    @(negedge clk_i);
    check("R9 abort on irq", {8'd0, abort_o}, 9'd1);
    @(negedge clk_i);
    check("R9 abort single cycle", {8'd0, abort_o}, 9'd0);
    irq_pend_i = 0;
    @(negedge clk_i);
    check("R9 wait disarmed", {8'd0, abort_o}, 9'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule